// File: doc/BRIEF.md
# Handshake-Fed Key Match Counter

This block takes a 16-bit search key from an outside producer and then counts how many words in a preloaded memory are equal to that key. The key arrives over a two-wire request/acknowledge exchange in which the block is the passive side. The producer raises a request with the key on the data lines. The block captures the key and only then answers with an acknowledge. It keeps the acknowledge up until the producer drops its request, and then it releases the acknowledge. Because of this exchange, the transfer works whatever the relative speeds of the producer and the block.

Once the exchange completes, the block zeroes its counter and sweeps the low 1024 words of a 16K-word memory in ascending order. For each address it spends one cycle issuing a read and one cycle capturing the returned word into a buffer register. The buffered word is compared with the stored key, and each equality adds one to the counter. When the sweep ends, a one-cycle done pulse marks the count as final. The count then holds until the next key is captured, and the block goes back to waiting for a request, indefinitely.

Top module: `keyScanCounter`

## Requirements
- R1: After reset (`rstN` low), `ack`, `scanDone` and `memRdEn` are 0 and `matchCount` is 0.
- R2: The key is captured from `keyIn` before `ack` rises. Changing `keyIn` after `ack` is high has no effect on the count.
- R3: `ack` rises while `req` is high and stays high for as long as `req` stays high. It is 0 by the first sample after the clock edge that sees `req` low.
- R4: `matchCount` reads 0 once the exchange completes, before any word of the new sweep has been counted.
- R5: The sweep issues exactly one read (`memRdEn` high) for each address 0 through 1023, in ascending order. It never presents an address above 1023.
- R6: The final `matchCount` equals the number of words at addresses 0 to 1023 that are equal to the key.
- R7: `scanDone` is high for exactly one cycle per sweep, and `matchCount` is final in that cycle.
- R8: After each sweep the block accepts a further key and runs a fresh sweep, without any reset.
- R9: `matchCount` is 11 bits wide and reports 1024 when every scanned word matches. It never exceeds 1024.
- R10: `matchCount` stays unchanged from the `scanDone` pulse until the next key is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Producer request, high while a key is offered |
| keyIn | input | 16 | Key offered by the producer |
| ack | output | 1 | Acknowledge to the producer, raised after the key is captured |
| memAddr | output | 14 | Memory word address |
| memRdEn | output | 1 | Memory read strobe; data is returned on the next clock |
| memRdData | input | 16 | Word returned by the memory |
| matchCount | output | 11 | Number of matching words in the latest sweep |
| scanDone | output | 1 | One-cycle pulse when the sweep count is final |

## Verification
A memory holding a repeating 4-bit ramp gives a known spread of matches. The same memory with a key that never occurs gives zero, which shows that the counter was cleared rather than carried over. A memory filled entirely with the key drives the counter to its full value of 1024. A memory where only the first and last scanned words match shows whether either end of the sweep is skipped. A set of words that each differ from the key in one bit shows whether the comparison checks every bit. Each key is followed by a corrupted value on the data lines once acknowledge is seen, so a block that samples the key late reports a wrong count.

// File: rtl/keyScanPkg.sv
package keyScanPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LATCH,
    S_HOLD,
    S_CLEAR,
    S_READ,
    S_COMPARE,
    S_DRAIN,
    S_DONE
  } scanState_t;

  typedef struct packed {
    logic loadKey;
    logic clearScan;
    logic readWord;
    logic loadMbr;
    logic stepAddr;
  } dpCtrl_t;

endpackage

// File: rtl/keyScanDatapath.sv
module keyScanDatapath
  import keyScanPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 14,
  parameter int SCAN_DEPTH = 1024,
  parameter int CNT_W      = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] keyIn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic [CNT_W-1:0]  matchCount,
  output logic              lastAddr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(SCAN_DEPTH - 1);
  localparam logic [CNT_W-1:0]  MAX_COUNT = CNT_W'(SCAN_DEPTH);

  logic [DATA_W-1:0] keyReg;
  logic [DATA_W-1:0] mbrReg;
  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  countReg;
  logic              cmpPending;
  logic              wordHit;

  // key register
  always_ff @(posedge clk) begin
    if (!rstN)            keyReg <= '0;
    else if (ctrl.loadKey) keyReg <= keyIn;
  end

  // memory buffer register and compare strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mbrReg     <= '0;
      cmpPending <= 1'b0;
    end else begin
      if (ctrl.loadMbr) mbrReg <= memRdData;
      cmpPending <= ctrl.loadMbr;
    end
  end

  assign wordHit = cmpPending && (mbrReg == keyReg);

  // address counter, holds at the last scanned address
  always_ff @(posedge clk) begin
    if (!rstN)                                  addrReg <= '0;
    else if (ctrl.clearScan)                    addrReg <= '0;
    else if (ctrl.stepAddr && addrReg != LAST_ADDR) addrReg <= addrReg + ADDR_W'(1);
  end

  // match counter
  always_ff @(posedge clk) begin
    if (!rstN)               countReg <= '0;
    else if (ctrl.clearScan) countReg <= '0;
    else if (wordHit)        countReg <= countReg + CNT_W'(1);
  end

  assign memAddr    = addrReg;
  assign memRdEn    = ctrl.readWord;
  assign matchCount = countReg;
  assign lastAddr   = (addrReg == LAST_ADDR);

  // R5: address never leaves the scanned window
  assert_addr_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    addrReg <= LAST_ADDR);

  // R9: counter never exceeds the window size
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    countReg <= MAX_COUNT);

  // R6: counter moves by one step or is cleared
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (countReg != $past(countReg)) |-> (countReg == $past(countReg) + CNT_W'(1) || countReg == '0));

  // R2: key is only replaced on a load strobe
  assert_key_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadKey |=> $stable(keyReg));

endmodule

// File: rtl/keyScanControl.sv
module keyScanControl
  import keyScanPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    lastAddr,
  output dpCtrl_t ctrl,
  output logic    ack,
  output logic    scanDone
);

  scanState_t state;
  scanState_t nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctrl      = '0;
    unique case (state)
      S_IDLE:    if (req) nextState = S_LATCH;
      S_LATCH: begin
        ctrl.loadKey = 1'b1;
        nextState    = S_HOLD;
      end
      S_HOLD:    if (!req) nextState = S_CLEAR;
      S_CLEAR: begin
        ctrl.clearScan = 1'b1;
        nextState      = S_READ;
      end
      S_READ: begin
        ctrl.readWord = 1'b1;
        nextState     = S_COMPARE;
      end
      S_COMPARE: begin
        ctrl.loadMbr  = 1'b1;
        ctrl.stepAddr = 1'b1;
        nextState     = lastAddr ? S_DRAIN : S_READ;
      end
      S_DRAIN:   nextState = S_DONE;
      S_DONE:    nextState = S_IDLE;
      default:   nextState = S_IDLE;
    endcase
  end

  assign ack      = (state == S_HOLD);
  assign scanDone = (state == S_DONE);

  // R3: acknowledge drops once request is seen low
  assert_ack_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !req) |=> !ack);

  // R3: acknowledge held while request stays high
  assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ack && req) |=> ack);

  // R7: done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);

  // R2: key captured the cycle before acknowledge rises
  assert_latch_before_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ack) |-> $past(ctrl.loadKey));

endmodule

// File: rtl/keyScanCounter.sv
module keyScanCounter
  import keyScanPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 14,
  parameter int SCAN_DEPTH = 1024,
  localparam int CNT_W     = $clog2(SCAN_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [DATA_W-1:0] keyIn,
  output logic              ack,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [CNT_W-1:0]  matchCount,
  output logic              scanDone
);

  dpCtrl_t ctrlBus;
  logic    lastAddr;

  keyScanControl u_control (
    .clk      (clk),
    .rstN     (rstN),
    .req      (req),
    .lastAddr (lastAddr),
    .ctrl     (ctrlBus),
    .ack      (ack),
    .scanDone (scanDone)
  );

  keyScanDatapath #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .SCAN_DEPTH (SCAN_DEPTH),
    .CNT_W      (CNT_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrlBus),
    .keyIn      (keyIn),
    .memRdData  (memRdData),
    .memAddr    (memAddr),
    .memRdEn    (memRdEn),
    .matchCount (matchCount),
    .lastAddr   (lastAddr)
  );

  // R10: count holds from the done pulse until the next capture
  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (scanDone || (!ctrlBus.clearScan && !memRdEn && !ctrlBus.loadMbr && $past(!ctrlBus.loadMbr) && !ack && $past(ack) == 1'b0 && !req))
      |=> $stable(matchCount));

endmodule

// File: tb/keyScanCounter_tb.sv
module keyScanCounter_tb_top;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic [15:0] keyIn = '0;
  logic        ack;
  logic [13:0] memAddr;
  logic        memRdEn;
  logic [15:0] memRdData = '0;
  logic [10:0] matchCount;
  logic        scanDone;

  logic [15:0] mem [0:DEPTH-1];
  int checks = 0;
  int errors = 0;
  int rdSeen = 0;
  int cycles = 0;
  bit prevDone = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  keyScanCounter dut_i (
    .clk(clk), .rstN(rstN), .req(req), .keyIn(keyIn), .ack(ack),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .matchCount(matchCount), .scanDone(scanDone)
  );

  // memory model: one-clock read latency
  always @(posedge clk) if (memRdEn) memRdData <= mem[memAddr[9:0]];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock reference: reads in order, done as a single pulse
  always @(negedge clk) begin
    if (rstN) begin
      if (memRdEn) begin
        check(memAddr == 14'(rdSeen), "R5 read address order", int'(memAddr), rdSeen);
        check(!ack, "R5 no read during handshake", int'(ack), 0);
        rdSeen++;
      end
      if (prevDone) check(!scanDone, "R7 done single cycle", int'(scanDone), 0);
      prevDone = scanDone;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int countMatches(input logic [15:0] key);
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] == key) n++;
    return n;
  endfunction

  task automatic sendKey(input logic [15:0] key);
    int expCount = countMatches(key);
    int guard;
    logic [10:0] held;
    rdSeen = 0;
    @(negedge clk);
    keyIn = key;
    req   = 1'b1;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!ack && guard < 20);
    check(ack, "R3 ack raised", int'(ack), 1);
    keyIn = ~key;  // R2: late change must not matter
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(ack, "R3 ack held while req high", int'(ack), 1);
    end
    req = 1'b0;
    @(negedge clk);
    check(!ack, "R3 ack released", int'(ack), 0);
    @(negedge clk);
    check(matchCount == 0, "R4 count cleared", int'(matchCount), 0);
    guard = 0;
    while (!scanDone && guard < 5000) begin @(negedge clk); guard++; end
    check(scanDone, "R7 done seen", int'(scanDone), 1);
    check(int'(matchCount) == expCount, "R6 R2 final count", int'(matchCount), expCount);
    check(rdSeen == DEPTH, "R5 read count", rdSeen, DEPTH);
    held = matchCount;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(matchCount == held, "R10 count holds", int'(matchCount), int'(held));
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'(i % 16);
    repeat (3) @(negedge clk);
    check(!ack, "R1 ack reset", int'(ack), 0);
    check(!scanDone, "R1 done reset", int'(scanDone), 0);
    check(!memRdEn, "R1 rden reset", int'(memRdEn), 0);
    check(matchCount == 0, "R1 count reset", int'(matchCount), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // ramp pattern, then absent key (R8: back-to-back keys)
    sendKey(16'h0005);
    sendKey(16'h0010);
    sendKey(16'h000F);

    // R9: every word matches
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'hA5A5;
    sendKey(16'hA5A5);
    check(matchCount == 11'd1024, "R9 full count", int'(matchCount), 1024);

    // R5: only the two ends match
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'h1234;
    mem[0] = 16'hBEEF;
    mem[DEPTH-1] = 16'hBEEF;
    sendKey(16'hBEEF);
    check(matchCount == 11'd2, "R5 both ends counted", int'(matchCount), 2);

    // single-bit differences
    for (int i = 0; i < DEPTH; i++)
      mem[i] = (i % 100 == 0) ? 16'hFFFF : (16'hFFFF ^ (16'd1 << (i % 16)));
    sendKey(16'hFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule